// File: doc/BRIEF.md
# Path-Tagged Trace Cache

This block stores short runs of instructions (or micro-ops) in the dynamic order in which they were fetched. Each stored trace holds up to 16 slots. It is identified by its start address together with the predicted directions of up to three conditional branches inside it. Because the path is part of the identity, two traces that begin at the same address but follow different branch directions can both be resident.

A fill unit delivers a finished trace on a valid/ready fill stream. Each beat carries the start PC, a branch count, the branch direction bits, a slot-valid mask, a fall-through next PC and the slot contents. `fill_ready` is high whenever reset is released, so a beat transfers in every cycle in which `fill_valid` is high and reset is inactive. The fetch side presents a PC and its predicted direction bits on a plain lookup port. In the same cycle it gets back a hit flag and the complete trace with its mask, count and next PC. The lookup port has no back-pressure, and a lookup hit counts as a use for replacement.

Trace storage is two-way set-associative with 32 sets. Each set has a single least-recently-used bit.

Top module: `path_trace_cache`

## Requirements
- R1: After reset every entry is invalid, every lookup misses, and `fill_ready` is low while `rst_n` is low and high once it is released.
- R2: A well-formed fill that is accepted (`fill_valid` and `fill_ready` both high at a rising edge) goes to set `pc[6:2]`. A later lookup of the same PC with matching direction bits then raises `lk_hit` combinationally in that same cycle and returns the stored slots, slot mask, branch count and next PC.
- R3: A lookup hits an entry only if predicted bits `[n-1:0]` equal the stored direction bits, where n is the stored branch count (0 to 3; bit 0 is the first branch, 1 means taken). Predicted bits at n and above are ignored. Two traces with the same start PC and different directions coexist.
- R4: A lookup whose PC differs from every valid entry of its set misses and drives `lk_slot_mask`, `lk_next_pc`, `lk_br_cnt` and `lk_slots` to zero.
- R5: A fill whose start PC, branch count and masked direction bits equal a resident entry overwrites that entry in place. The other way of the set is untouched.
- R6: A fill with no matching entry uses an empty way (way 0 before way 1), or else the least recently used way. Both a lookup hit and a fill make the touched way the most recently used, and the fill decides if both touch one set in the same cycle.
- R7: When a fill and a lookup occur in the same cycle, the lookup sees the contents from before the fill. The filled trace can be looked up from the next cycle on.
- R8: An accepted fill whose slot mask is zero, or is not a contiguous run of ones starting at slot 0, is discarded and leaves the cache unchanged.
- R9: When two entries of a set both match a lookup, the one with the larger branch count is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_valid | input | 1 | Fill beat present |
| fill_ready | output | 1 | Fill beat can be taken |
| fill_pc | input | 32 | Start PC of the trace |
| fill_br_cnt | input | 2 | Conditional branches in the trace (0..3) |
| fill_br_taken | input | 3 | Branch directions, bit 0 first |
| fill_slot_mask | input | 16 | Occupied slots, must be a prefix |
| fill_next_pc | input | 32 | Fall-through PC after the trace |
| fill_slots | input | 512 | Slot contents, slot 0 in the low bits |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 32 | Lookup start PC |
| lk_pred | input | 3 | Predicted branch directions, bit 0 first |
| lk_hit | output | 1 | Lookup hit |
| lk_br_cnt | output | 2 | Branch count of the returned trace |
| lk_slot_mask | output | 16 | Slot-valid mask of the returned trace |
| lk_next_pc | output | 32 | Fall-through PC of the returned trace |
| lk_slots | output | 512 | Returned trace contents |

## Verification
The hardest situation to create is a fill and a lookup on the same set in the same clock cycle. Both ports are driven in one cycle with the same PC. The bench samples the miss before the edge and the hit after it. Overlapping path matches are also hard to reach: they need a branch-free trace and a two-branch trace with the same start PC in one set. The bench builds that pair on purpose and then probes it with direction patterns that match one entry or both.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int WAYS   = 2;
  localparam int CNT_W  = 2;
  localparam int DIR_W  = 3;

  // Keeps only the direction bits covered by a branch count.
  function automatic logic [DIR_W-1:0] dir_keep(input logic [CNT_W-1:0] n);
    logic [DIR_W:0] t;
    t = ({{DIR_W{1'b0}}, 1'b1} << n) - 1'b1;
    return t[DIR_W-1:0];
  endfunction
endpackage

// File: rtl/tc_way_match.sv
module tc_way_match
  import tc_pkg::*;
#(
  parameter int  PC_W  = 32,
  parameter bit  EXACT = 1'b0
) (
  input  logic               ent_v,
  input  logic [PC_W-1:0]    ent_pc,
  input  logic [CNT_W-1:0]   ent_cnt,
  input  logic [DIR_W-1:0]   ent_dir,
  input  logic [PC_W-1:0]    q_pc,
  input  logic [CNT_W-1:0]   q_cnt,
  input  logic [DIR_W-1:0]   q_dir,
  output logic               match
);
  generate
    if (EXACT) begin : g_exact
      // Fill side: full tag identity, q_dir already trimmed by caller.
      assign match = ent_v && (ent_pc == q_pc) && (ent_cnt == q_cnt)
                     && (ent_dir == q_dir);
    end else begin : g_path
      // Lookup side: only directions covered by the stored count matter.
      logic unused_cnt;
      assign unused_cnt = ^q_cnt;
      assign match = ent_v && (ent_pc == q_pc)
                     && (((q_dir ^ ent_dir) & dir_keep(ent_cnt)) == '0);
    end
  endgenerate
endmodule

// File: rtl/tc_lru.sv
module tc_lru
  import tc_pkg::*;
#(
  parameter int SETS  = 32,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_upd,
  input  logic [SET_W-1:0] lk_set,
  input  logic             lk_way,
  input  logic             fl_upd,
  input  logic [SET_W-1:0] fl_set,
  input  logic             fl_way,
  input  logic [SET_W-1:0] q_set,
  output logic             q_victim
);
  logic [SETS-1:0] old_q;   // bit = least recently used way of that set

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      old_q <= '0;
    end else begin
      if (lk_upd) old_q[lk_set] <= ~lk_way;
      if (fl_upd) old_q[fl_set] <= ~fl_way;   // fill wins on a shared set
    end
  end

  assign q_victim = old_q[q_set];

  p_fill_mru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fl_upd |=> old_q[$past(fl_set)] != $past(fl_way));

  p_hit_mru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_upd && !(fl_upd && fl_set == lk_set)) |=> old_q[$past(lk_set)] != $past(lk_way));
endmodule

// File: rtl/path_trace_cache.sv
module path_trace_cache
  import tc_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int SLOT_W  = 32,
  parameter int SLOTS   = 16,
  parameter int SETS    = 32,
  parameter int IDX_LSB = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fill_valid,
  output logic                    fill_ready,
  input  logic [PC_W-1:0]         fill_pc,
  input  logic [CNT_W-1:0]        fill_br_cnt,
  input  logic [DIR_W-1:0]        fill_br_taken,
  input  logic [SLOTS-1:0]        fill_slot_mask,
  input  logic [PC_W-1:0]         fill_next_pc,
  input  logic [SLOTS*SLOT_W-1:0] fill_slots,
  input  logic                    lk_valid,
  input  logic [PC_W-1:0]         lk_pc,
  input  logic [DIR_W-1:0]        lk_pred,
  output logic                    lk_hit,
  output logic [CNT_W-1:0]        lk_br_cnt,
  output logic [SLOTS-1:0]        lk_slot_mask,
  output logic [PC_W-1:0]         lk_next_pc,
  output logic [SLOTS*SLOT_W-1:0] lk_slots
);
  localparam int SET_W  = $clog2(SETS);
  localparam int DATA_W = SLOTS * SLOT_W;

  // ---------------- storage ----------------
  logic [SETS-1:0]   v_q    [WAYS];
  logic [PC_W-1:0]   pc_q   [WAYS][SETS];
  logic [CNT_W-1:0]  cnt_q  [WAYS][SETS];
  logic [DIR_W-1:0]  dir_q  [WAYS][SETS];
  logic [SLOTS-1:0]  msk_q  [WAYS][SETS];
  logic [PC_W-1:0]   npc_q  [WAYS][SETS];
  logic [DATA_W-1:0] dat_q  [WAYS][SETS];

  logic [SET_W-1:0] lk_set, fl_set;
  assign lk_set = lk_pc[IDX_LSB +: SET_W];
  assign fl_set = fill_pc[IDX_LSB +: SET_W];

  // ---------------- fill acceptance ----------------
  logic             fill_fire, mask_ok, fill_ok;
  logic [DIR_W-1:0] fl_dir;
  assign fill_ready = rst_n;
  assign fill_fire  = fill_valid && fill_ready;
  assign mask_ok    = (fill_slot_mask != '0)
                      && ((fill_slot_mask & (fill_slot_mask + 1'b1)) == '0);
  assign fill_ok    = fill_fire && mask_ok;
  assign fl_dir     = fill_br_taken & dir_keep(fill_br_cnt);

  // ---------------- per-way tag compare ----------------
  logic [WAYS-1:0] lk_m, fl_m, fl_v;
  logic [CNT_W-1:0] rd_cnt [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign rd_cnt[w] = cnt_q[w][lk_set];
    assign fl_v[w]   = v_q[w][fl_set];

    tc_way_match #(.PC_W(PC_W), .EXACT(1'b0)) u_lk (
      .ent_v  (v_q[w][lk_set]),
      .ent_pc (pc_q[w][lk_set]),
      .ent_cnt(cnt_q[w][lk_set]),
      .ent_dir(dir_q[w][lk_set]),
      .q_pc   (lk_pc),
      .q_cnt  ('0),
      .q_dir  (lk_pred),
      .match  (lk_m[w])
    );

    tc_way_match #(.PC_W(PC_W), .EXACT(1'b1)) u_fl (
      .ent_v  (v_q[w][fl_set]),
      .ent_pc (pc_q[w][fl_set]),
      .ent_cnt(cnt_q[w][fl_set]),
      .ent_dir(dir_q[w][fl_set]),
      .q_pc   (fill_pc),
      .q_cnt  (fill_br_cnt),
      .q_dir  (fl_dir),
      .match  (fl_m[w])
    );
  end

  // ---------------- lookup select ----------------
  logic sel_w, any_m;
  assign any_m = |lk_m;
  always_comb begin
    if (lk_m[0] && lk_m[1]) sel_w = (rd_cnt[1] > rd_cnt[0]);
    else                    sel_w = lk_m[1];
  end
  assign lk_hit = lk_valid && any_m;

  always_comb begin
    lk_br_cnt    = '0;
    lk_slot_mask = '0;
    lk_next_pc   = '0;
    lk_slots     = '0;
    if (lk_hit) begin
      lk_br_cnt    = cnt_q[sel_w][lk_set];
      lk_slot_mask = msk_q[sel_w][lk_set];
      lk_next_pc   = npc_q[sel_w][lk_set];
      lk_slots     = dat_q[sel_w][lk_set];
    end
  end

  // ---------------- replacement ----------------
  logic victim, fl_way;
  always_comb begin
    if      (fl_m[0]) fl_way = 1'b0;
    else if (fl_m[1]) fl_way = 1'b1;
    else if (!fl_v[0]) fl_way = 1'b0;
    else if (!fl_v[1]) fl_way = 1'b1;
    else               fl_way = victim;
  end

  tc_lru #(.SETS(SETS)) u_lru (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_upd  (lk_hit),
    .lk_set  (lk_set),
    .lk_way  (sel_w),
    .fl_upd  (fill_ok),
    .fl_set  (fl_set),
    .fl_way  (fl_way),
    .q_set   (fl_set),
    .q_victim(victim)
  );

  // ---------------- writes ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) v_q[w] <= '0;
    end else if (fill_ok) begin
      v_q[fl_way][fl_set] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_ok) begin
      pc_q [fl_way][fl_set] <= fill_pc;
      cnt_q[fl_way][fl_set] <= fill_br_cnt;
      dir_q[fl_way][fl_set] <= fl_dir;
      msk_q[fl_way][fl_set] <= fill_slot_mask;
      npc_q[fl_way][fl_set] <= fill_next_pc;
      dat_q[fl_way][fl_set] <= fill_slots;
    end
  end

  // ---------------- assertions ----------------
  p_hit_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> pc_q[sel_w][lk_set] == lk_pc);

  p_fill_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ok |=> v_q[$past(fl_way)][$past(fl_set)]
                && pc_q[$past(fl_way)][$past(fl_set)] == $past(fill_pc));

  p_prefix_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_slot_mask != '0) && ((lk_slot_mask & (lk_slot_mask + 1'b1)) == '0));

  p_unique_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ok |=> !(v_q[0][$past(fl_set)] && v_q[1][$past(fl_set)]
                  && pc_q[0][$past(fl_set)] == pc_q[1][$past(fl_set)]
                  && cnt_q[0][$past(fl_set)] == cnt_q[1][$past(fl_set)]
                  && dir_q[0][$past(fl_set)] == dir_q[1][$past(fl_set)]));

  p_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ready);
endmodule

// File: tb/path_trace_cache_bench.sv
module path_trace_cache_bench;
  localparam int PC_W = 32, SLOT_W = 32, SLOTS = 16;
  localparam int DW = SLOTS * SLOT_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fill_valid = 1'b0, fill_ready;
  logic [PC_W-1:0] fill_pc = '0, fill_next_pc = '0, lk_pc = '0, lk_next_pc;
  logic [1:0] fill_br_cnt = '0, lk_br_cnt;
  logic [2:0] fill_br_taken = '0, lk_pred = '0;
  logic [SLOTS-1:0] fill_slot_mask = '0, lk_slot_mask;
  logic [DW-1:0] fill_slots = '0, lk_slots;
  logic lk_valid = 1'b0, lk_hit;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  path_trace_cache u_path_trace_cache (.*);

  function automatic logic [DW-1:0] mk_data(input int seed);
    logic [DW-1:0] d;
    for (int i = 0; i < SLOTS; i++) d[i*SLOT_W +: SLOT_W] = {seed[15:0], i[15:0]};
    return d;
  endfunction

  function automatic logic [PC_W-1:0] mk_pc(input int hi, input int set);
    return PC_W'((hi << 7) | (set << 2));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_fill(input logic [PC_W-1:0] pc, input logic [1:0] cnt,
                         input logic [2:0] dir, input logic [SLOTS-1:0] msk,
                         input int seed);
    @(negedge clk);
    fill_valid = 1'b1; fill_pc = pc; fill_br_cnt = cnt; fill_br_taken = dir;
    fill_slot_mask = msk; fill_next_pc = pc + 32'h40; fill_slots = mk_data(seed);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  // Lookup: outputs are combinational, sampled 1 ns after the inputs change.
  task automatic look(input string req, input logic [PC_W-1:0] pc, input logic [2:0] pred,
                      input bit exp_hit, input logic [1:0] cnt,
                      input logic [SLOTS-1:0] msk, input int seed);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = pc; lk_pred = pred;
    #1;
    check(lk_hit == exp_hit, req, "hit", 64'(lk_hit), 64'(exp_hit));
    if (exp_hit) begin
      check(lk_slots == mk_data(seed) && lk_br_cnt == cnt && lk_slot_mask == msk
            && lk_next_pc == pc + 32'h40, req, "trace",
            64'(lk_slots[31:0]), 64'(mk_data(seed) & 32'hffffffff));
    end else begin
      check(lk_slots == '0 && lk_slot_mask == '0 && lk_next_pc == '0 && lk_br_cnt == '0,
            req, "miss outputs", 64'(lk_slot_mask), 64'd0);
    end
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    check(fill_ready == 1'b0, "R1", "ready in reset", 64'(fill_ready), 64'd0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(fill_ready == 1'b1, "R1", "ready after reset", 64'(fill_ready), 64'd1);
    look("R1", mk_pc(1, 0), 3'b000, 1'b0, 0, 0, 0);
    look("R1", mk_pc(0, 0), 3'b000, 1'b0, 0, 0, 0);
  endtask

  task automatic t_basic;
    do_fill(mk_pc(2, 1), 2'd1, 3'b001, 16'hffff, 11);
    look("R2", mk_pc(2, 1), 3'b001, 1'b1, 2'd1, 16'hffff, 11);
    look("R2", mk_pc(2, 2), 3'b001, 1'b0, 0, 0, 0);
  endtask

  task automatic t_paths;
    do_fill(mk_pc(3, 3), 2'd2, 3'b001, 16'h00ff, 21);
    do_fill(mk_pc(3, 3), 2'd2, 3'b010, 16'h003f, 22);
    look("R3", mk_pc(3, 3), 3'b101, 1'b1, 2'd2, 16'h00ff, 21);
    look("R3", mk_pc(3, 3), 3'b110, 1'b1, 2'd2, 16'h003f, 22);
    look("R3", mk_pc(3, 3), 3'b011, 1'b0, 0, 0, 0);
    look("R3", mk_pc(3, 3), 3'b000, 1'b0, 0, 0, 0);
    look("R4", mk_pc(4, 3), 3'b001, 1'b0, 0, 0, 0);
    // same tag as seed 21 once bit 2 is trimmed: overwrite in place
    do_fill(mk_pc(3, 3), 2'd2, 3'b101, 16'h0fff, 23);
    look("R5", mk_pc(3, 3), 3'b001, 1'b1, 2'd2, 16'h0fff, 23);
    look("R5", mk_pc(3, 3), 3'b010, 1'b1, 2'd2, 16'h003f, 22);
  endtask

  task automatic t_lru;
    do_fill(mk_pc(5, 5), 2'd0, 3'b000, 16'h0001, 31);
    do_fill(mk_pc(6, 5), 2'd0, 3'b000, 16'h0001, 32);
    do_fill(mk_pc(7, 5), 2'd0, 3'b000, 16'h0001, 33);
    look("R6", mk_pc(5, 5), 3'b000, 1'b0, 0, 0, 0);
    look("R6", mk_pc(6, 5), 3'b000, 1'b1, 2'd0, 16'h0001, 32);
    look("R6", mk_pc(7, 5), 3'b000, 1'b1, 2'd0, 16'h0001, 33);
    do_fill(mk_pc(5, 6), 2'd0, 3'b000, 16'h0003, 41);
    do_fill(mk_pc(6, 6), 2'd0, 3'b000, 16'h0003, 42);
    look("R6", mk_pc(5, 6), 3'b000, 1'b1, 2'd0, 16'h0003, 41);
    do_fill(mk_pc(7, 6), 2'd0, 3'b000, 16'h0003, 43);
    look("R6", mk_pc(6, 6), 3'b000, 1'b0, 0, 0, 0);
    look("R6", mk_pc(5, 6), 3'b000, 1'b1, 2'd0, 16'h0003, 41);
    look("R6", mk_pc(7, 6), 3'b000, 1'b1, 2'd0, 16'h0003, 43);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    fill_valid = 1'b1; fill_pc = mk_pc(8, 7); fill_br_cnt = 2'd0; fill_br_taken = 3'b000;
    fill_slot_mask = 16'h000f; fill_next_pc = mk_pc(8, 7) + 32'h40; fill_slots = mk_data(51);
    lk_valid = 1'b1; lk_pc = mk_pc(8, 7); lk_pred = 3'b000;
    #1;
    check(lk_hit == 1'b0, "R7", "lookup sees old contents", 64'(lk_hit), 64'd0);
    @(negedge clk);
    fill_valid = 1'b0;
    #1;
    check(lk_hit == 1'b1 && lk_slots == mk_data(51), "R7", "visible next cycle",
          64'(lk_hit), 64'd1);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic t_malformed;
    do_fill(mk_pc(9, 8), 2'd0, 3'b000, 16'h0005, 61);
    look("R8", mk_pc(9, 8), 3'b000, 1'b0, 0, 0, 0);
    do_fill(mk_pc(9, 8), 2'd0, 3'b000, 16'h0000, 62);
    look("R8", mk_pc(9, 8), 3'b000, 1'b0, 0, 0, 0);
    do_fill(mk_pc(9, 8), 2'd0, 3'b000, 16'h0001, 63);
    look("R8", mk_pc(9, 8), 3'b000, 1'b1, 2'd0, 16'h0001, 63);
  endtask

  task automatic t_longest;
    do_fill(mk_pc(10, 9), 2'd0, 3'b000, 16'h0007, 71);
    do_fill(mk_pc(10, 9), 2'd2, 3'b011, 16'h01ff, 72);
    look("R9", mk_pc(10, 9), 3'b011, 1'b1, 2'd2, 16'h01ff, 72);
    look("R9", mk_pc(10, 9), 3'b111, 1'b1, 2'd2, 16'h01ff, 72);
    look("R9", mk_pc(10, 9), 3'b001, 1'b1, 2'd0, 16'h0007, 71);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_basic();
    t_paths();
    t_lru();
    t_same_cycle();
    t_malformed();
    t_longest();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule